// File: doc/BRIEF.md
# DRAM Bank Timing Tracker

This block sits in a memory controller. It follows the state of four DRAM banks and tells the command scheduler which commands each bank can take on the next clock edge. Each bank keeps its own open row, so work on one bank can overlap work on another. Every clock edge the tracker samples one command code, a bank number, an auto-precharge flag and a speed-grade select. From these it keeps down-counters for the row-to-column delay, the minimum row-active time, the minimum activate-to-activate time and the precharge recovery time of every bank.

It drives three ready vectors, each one bit per bank: activate allowed, read/write allowed and precharge allowed. A scheduler that follows these vectors never breaks a bank timing minimum. If a command arrives that a ready flag forbids, the tracker leaves the bank state as it was and pulses an error flag. A read or write that carries auto-precharge is handled as a deferred precharge. The bank closes itself once the burst and the minimum active time have both run out.

Top module: `bank_timing_tracker`

## Requirements
- R1: While reset is held, and after it is released with no command issued, every bank is closed: `actReady` is 4'b1111, `rwReady` and `preReady` are 4'b0000, and `cmdError` is 0.
- R2: An activate accepted at edge A opens the bank. A read or write to that bank is first accepted at edge A+tRCD, and `rwReady` for it reads 1 from the cycle just before that edge.
- R3: A precharge to an open bank is accepted from edge A+tRAS onward. A precharge accepted at edge P closes the bank, and a new activate is first accepted at edge P+tRP.
- R4: Two activates to the same bank are at least tRC edges apart, and an activate to an open bank is refused.
- R5: `speedBin` selects the cycle counts tRCD/tRP/tRAS/tRC as follows: 0 gives 3/3/8/11, 1 gives 4/4/12/16, 2 gives 5/5/15/20, 3 gives 4/4/15/19. Each count is loaded with the select value present at the edge that starts it.
- R6: A read or write accepted at edge E with `autoPre`=1 closes the bank at edge max(E+BURST_CYCLES, A+tRAS), where BURST_CYCLES defaults to 4. Until then the bank takes no read, write, precharge or activate. After the close, an activate is accepted from the close edge plus tRP.
- R7: A refused command drives `cmdError` high for exactly the cycle after its edge and leaves the bank state unchanged. An accepted command gives `cmdError`=0.
- R8: A command to one bank changes the ready flags and counters of no other bank.
- R9: Command codes: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge. Codes 0, 5, 6 and 7 change no bank and never raise `cmdError`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdCode | input | 3 | Command code for this edge (see R9) |
| cmdBank | input | 2 | Target bank of the command |
| autoPre | input | 1 | Auto-precharge option for read and write |
| speedBin | input | 2 | Speed-grade select for the timing counts |
| actReady | output | 4 | Per bank: an activate is legal on the next edge |
| rwReady | output | 4 | Per bank: a read or write is legal on the next edge |
| preReady | output | 4 | Per bank: a precharge is legal on the next edge |
| cmdError | output | 1 | One-cycle pulse after a refused command |

## Verification
Each command lands on one rising edge. The error pulse for that command and the updated ready vectors, which describe legality at the following edge, are due one register stage later. The bench samples them on the falling edge that follows the command's edge. A bench-side model keeps the edge number of each bank's last activate, precharge and pending auto-close. From these it computes what must hold at the next edge, so every counter boundary (tRCD, tRAS, tRP, tRC and the burst end) is compared in the exact cycle in which it expires.

// File: rtl/bank_timer_pkg.sv
package bank_timer_pkg;

  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int TIM_W     = 5;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef struct packed {
    logic [TIM_W-1:0] rcd;
    logic [TIM_W-1:0] rp;
    logic [TIM_W-1:0] ras;
    logic [TIM_W-1:0] rc;
  } timing_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              act;
    logic              pre;
    logic              rwAp;
    logic [BANK_W-1:0] bank;
  } strobe_t;

  function automatic logic [TIM_W-1:0] nsToCycles(input int ns, input int periodPs);
    return TIM_W'((ns * 1000 + periodPs - 1) / periodPs);
  endfunction

  function automatic timing_t binTiming(input logic [1:0] bin);
    int periodPs, rcdNs, rasNs, rcNs;
    timing_t t;
    case (bin)
      2'd0:    begin periodPs = 5000; rcdNs = 15; rasNs = 40; rcNs = 55; end
      2'd1:    begin periodPs = 3750; rcdNs = 15; rasNs = 45; rcNs = 60; end
      2'd2:    begin periodPs = 3000; rcdNs = 15; rasNs = 45; rcNs = 60; end
      default: begin periodPs = 3000; rcdNs = 12; rasNs = 45; rcNs = 57; end
    endcase
    t.rcd = nsToCycles(rcdNs, periodPs);
    t.rp  = nsToCycles(rcdNs, periodPs);
    t.ras = nsToCycles(rasNs, periodPs);
    t.rc  = nsToCycles(rcNs, periodPs);
    return t;
  endfunction

endpackage

// File: rtl/btt_ctrl.sv
module btt_ctrl
  import bank_timer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           cmdCode,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic                 autoPre,
  input  logic [NUM_BANKS-1:0] actReady,
  input  logic [NUM_BANKS-1:0] rwReady,
  input  logic [NUM_BANKS-1:0] preReady,
  output strobe_t              stb,
  output logic                 cmdError
);

  logic isCmd;
  logic isOk;

  always_comb begin
    stb      = '0;
    stb.bank = cmdBank;
    isCmd    = 1'b1;
    isOk     = 1'b1;
    case (cmdCode)
      CMD_ACT: begin
        isOk    = actReady[cmdBank];
        stb.act = isOk;
      end
      CMD_RD, CMD_WR: begin
        isOk     = rwReady[cmdBank];
        stb.rwAp = isOk && autoPre;
      end
      CMD_PRE: begin
        isOk    = preReady[cmdBank];
        stb.pre = isOk;
      end
      default: isCmd = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdError <= 1'b0;
    else       cmdError <= isCmd && !isOk;
  end

endmodule

// File: rtl/btt_datapath.sv
module btt_datapath
  import bank_timer_pkg::*;
#(
  parameter int BURST_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           speedBin,
  input  strobe_t              stb,
  output logic [NUM_BANKS-1:0] actReady,
  output logic [NUM_BANKS-1:0] rwReady,
  output logic [NUM_BANKS-1:0] preReady
);

  localparam int BURST_W = $clog2(BURST_CYCLES + 1);

  timing_t tim;
  assign tim = binTiming(speedBin);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             isOpen;
    logic             apPend;
    logic [TIM_W-1:0] rcdCnt, rasCnt, rcCnt, rpCnt;
    logic [BURST_W-1:0] burstCnt;
    logic             hit;
    logic             apClose;

    assign hit     = (stb.bank == BANK_W'(b));
    assign apClose = apPend && (burstCnt == '0) && (rasCnt == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        isOpen   <= 1'b0;
        apPend   <= 1'b0;
        rcdCnt   <= '0;
        rasCnt   <= '0;
        rcCnt    <= '0;
        rpCnt    <= '0;
        burstCnt <= '0;
      end else begin
        if (rcdCnt != '0) rcdCnt <= rcdCnt - 1'b1;
        if (rasCnt != '0) rasCnt <= rasCnt - 1'b1;
        if (rcCnt  != '0) rcCnt  <= rcCnt  - 1'b1;
        if (rpCnt  != '0) rpCnt  <= rpCnt  - 1'b1;
        if (apPend && burstCnt != '0) burstCnt <= burstCnt - 1'b1;

        if (apClose) begin
          apPend <= 1'b0;
          isOpen <= 1'b0;
          rpCnt  <= tim.rp - 1'b1;
        end
        if (hit && stb.act) begin
          isOpen <= 1'b1;
          rcdCnt <= tim.rcd - 1'b1;
          rasCnt <= tim.ras - 1'b1;
          rcCnt  <= tim.rc - 1'b1;
        end
        if (hit && stb.pre) begin
          isOpen <= 1'b0;
          rpCnt  <= tim.rp - 1'b1;
        end
        if (hit && stb.rwAp) begin
          apPend   <= 1'b1;
          burstCnt <= BURST_W'(BURST_CYCLES - 1);
        end
      end
    end

    assign actReady[b] = !isOpen && (rpCnt == '0) && (rcCnt == '0);
    assign rwReady[b]  = isOpen && !apPend && (rcdCnt == '0);
    assign preReady[b] = isOpen && !apPend && (rasCnt == '0);
  end

endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker
  import bank_timer_pkg::*;
#(
  parameter int BURST_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           cmdCode,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic                 autoPre,
  input  logic [1:0]           speedBin,
  output logic [NUM_BANKS-1:0] actReady,
  output logic [NUM_BANKS-1:0] rwReady,
  output logic [NUM_BANKS-1:0] preReady,
  output logic                 cmdError
);

  strobe_t stb;

  btt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdCode  (cmdCode),
    .cmdBank  (cmdBank),
    .autoPre  (autoPre),
    .actReady (actReady),
    .rwReady  (rwReady),
    .preReady (preReady),
    .stb      (stb),
    .cmdError (cmdError)
  );

  btt_datapath #(.BURST_CYCLES(BURST_CYCLES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .speedBin (speedBin),
    .stb      (stb),
    .actReady (actReady),
    .rwReady  (rwReady),
    .preReady (preReady)
  );

endmodule

// File: rtl/btt_checker.sv
module btt_checker
  import bank_timer_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [2:0]           cmdCode,
  input logic [BANK_W-1:0]    cmdBank,
  input logic                 autoPre,
  input logic [1:0]           speedBin,
  input logic [NUM_BANKS-1:0] actReady,
  input logic [NUM_BANKS-1:0] rwReady,
  input logic [NUM_BANKS-1:0] preReady,
  input logic                 cmdError
);

  logic isAct, isRw, isPre;
  assign isAct = (cmdCode == CMD_ACT);
  assign isRw  = (cmdCode == CMD_RD) || (cmdCode == CMD_WR);
  assign isPre = (cmdCode == CMD_PRE);

  logic unusedSig;
  assign unusedSig = autoPre ^ (^speedBin);

  p_act_refused_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isAct && !actReady[cmdBank]) |=> cmdError);

  p_rw_refused_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isRw && !rwReady[cmdBank]) |=> cmdError);

  p_pre_refused_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isPre && !preReady[cmdBank]) |=> cmdError);

  p_quiet_codes_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(isAct || isRw || isPre) |=> !cmdError);

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isAct && actReady[cmdBank]) |=>
      (!actReady[$past(cmdBank)] && !rwReady[$past(cmdBank)] && !preReady[$past(cmdBank)]));

  p_pre_closes_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isPre && preReady[cmdBank]) |=>
      (!actReady[$past(cmdBank)] && !rwReady[$past(cmdBank)] && !preReady[$past(cmdBank)]));

  p_accept_no_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((isAct && actReady[cmdBank]) || (isPre && preReady[cmdBank])) |=> !cmdError);

  p_no_open_act_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!unusedSig || unusedSig) |-> !(actReady & (rwReady | preReady)));

endmodule

bind bank_timing_tracker btt_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdCode  (cmdCode),
  .cmdBank  (cmdBank),
  .autoPre  (autoPre),
  .speedBin (speedBin),
  .actReady (actReady),
  .rwReady  (rwReady),
  .preReady (preReady),
  .cmdError (cmdError)
);

// File: tb/sim_bank_timing_tracker.sv
`timescale 1ns/1ps
module sim_bank_timing_tracker;

  localparam int NB = 4;
  localparam int BURST = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cmdCode = 3'd0;
  logic [1:0] cmdBank = 2'd0;
  logic       autoPre = 1'b0;
  logic [1:0] speedBin = 2'd0;
  logic [3:0] actReady, rwReady, preReady;
  logic       cmdError;

  always #5 clk = ~clk;

  bank_timing_tracker #(.BURST_CYCLES(BURST)) u0 (
    .clk(clk), .rstN(rstN), .cmdCode(cmdCode), .cmdBank(cmdBank),
    .autoPre(autoPre), .speedBin(speedBin), .actReady(actReady),
    .rwReady(rwReady), .preReady(preReady), .cmdError(cmdError)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state, edge numbers since reset
  int  edgeN = 0;
  bit  mOpen [NB];
  bit  mAp   [NB];
  int  actE  [NB];
  int  preE  [NB];
  int  closeE[NB];
  int  mRcd[NB], mRas[NB], mRc[NB], mRp[NB];

  // cycle counts per speed select, from R5
  function automatic int tval(input int bin, input int which);
    int tab [4][4] = '{'{3,3,8,11}, '{4,4,12,16}, '{5,5,15,20}, '{4,4,15,19}};
    return tab[bin][which];
  endfunction

  function automatic bit legalAt(input int b, input int code, input int e);
    case (code)
      1: return !mOpen[b] && !mAp[b] && e >= preE[b] + mRp[b] && e >= actE[b] + mRc[b];
      2, 3: return mOpen[b] && !mAp[b] && e >= actE[b] + mRcd[b];
      4: return mOpen[b] && !mAp[b] && e >= actE[b] + mRas[b];
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at edge %0d", tag, what, act, exp, edgeN);
    end
  endtask

  task automatic modelReset();
    for (int b = 0; b < NB; b++) begin
      mOpen[b] = 0; mAp[b] = 0; actE[b] = -1000; preE[b] = -1000; closeE[b] = 0;
      mRcd[b] = 3; mRas[b] = 8; mRc[b] = 11; mRp[b] = 3;
    end
  endtask

  task automatic step(input int code, input int bank, input bit ap, input string tag);
    int e;
    bit ok;
    bit expErr;
    logic [3:0] eAct, eRw, ePre;
    cmdCode = 3'(code); cmdBank = 2'(bank); autoPre = ap;
    @(posedge clk);
    e = edgeN;
    ok = legalAt(bank, code, e);
    expErr = (code >= 1 && code <= 4) && !ok;
    if (ok) begin
      case (code)
        1: begin
          mOpen[bank] = 1; actE[bank] = e;
          mRcd[bank] = tval(speedBin, 0); mRas[bank] = tval(speedBin, 2);
          mRc[bank] = tval(speedBin, 3);
        end
        2, 3: if (ap) begin
          mAp[bank] = 1;
          closeE[bank] = (e + BURST > actE[bank] + mRas[bank]) ? e + BURST : actE[bank] + mRas[bank];
        end
        4: begin mOpen[bank] = 0; preE[bank] = e; mRp[bank] = tval(speedBin, 1); end
        default: ;
      endcase
    end
    for (int b = 0; b < NB; b++)
      if (mAp[b] && closeE[b] == e) begin
        mAp[b] = 0; mOpen[b] = 0; preE[b] = e; mRp[b] = tval(speedBin, 1);
      end
    edgeN++;
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      eAct[b] = legalAt(b, 1, edgeN);
      eRw[b]  = legalAt(b, 2, edgeN);
      ePre[b] = legalAt(b, 4, edgeN);
    end
    check(tag, "cmdError", int'(cmdError), int'(expErr));
    check(tag, "actReady", int'(actReady), int'(eAct));
    check(tag, "rwReady", int'(rwReady), int'(eRw));
    check(tag, "preReady", int'(preReady), int'(ePre));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int first;
    void'($urandom(32'd7321));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    check("R1", "actReady", int'(actReady), 4'hF);
    check("R1", "rwReady", int'(rwReady), 0);
    check("R1", "preReady", int'(preReady), 0);
    check("R1", "cmdError", int'(cmdError), 0);
    rstN = 1'b1;
    idle(2, "R1");

    // R2: tRCD boundary in bin 0, early read refused
    step(1, 0, 0, "R2");
    step(2, 0, 0, "R2");           // edge A+1, refused
    step(2, 0, 0, "R2");           // edge A+2, refused
    first = edgeN;
    step(2, 0, 0, "R2");           // edge A+3, accepted
    check("R2", "read accepted at A+tRCD", int'(cmdError), 0);
    // R3: tRAS then tRP
    step(4, 0, 0, "R3");           // refused, A+4
    idle(3, "R3");
    step(4, 0, 0, "R3");           // A+8 accepted
    step(1, 0, 0, "R3");           // refused during tRP
    idle(1, "R3");
    step(1, 0, 0, "R3");           // accepted at P+3
    // R4: activate to open bank refused
    step(1, 0, 0, "R4");
    check("R4", "act to open bank", int'(cmdError), 1);
    idle(8, "R4");
    step(4, 0, 0, "R4");
    idle(4, "R4");

    // R8: two banks overlapping
    step(1, 1, 0, "R8");
    step(1, 2, 0, "R8");
    step(2, 1, 0, "R8");
    idle(3, "R8");
    step(3, 2, 0, "R8");
    step(4, 3, 0, "R8");
    idle(10, "R8");
    step(4, 1, 0, "R8");
    step(4, 2, 0, "R8");
    idle(5, "R8");

    // R6: auto-precharge close bounded by tRAS, then by burst end
    step(1, 0, 0, "R6");
    idle(2, "R6");
    step(2, 0, 1, "R6");
    step(2, 0, 0, "R6");           // refused while close pending
    step(4, 0, 0, "R6");           // refused while close pending
    idle(10, "R6");
    step(1, 3, 0, "R6");
    idle(10, "R6");
    step(3, 3, 1, "R6");
    idle(9, "R6");

    // R9: reserved codes do nothing
    step(1, 2, 0, "R9");
    step(5, 2, 0, "R9");
    step(6, 2, 1, "R9");
    step(7, 2, 0, "R9");
    check("R9", "reserved code error", int'(cmdError), 0);
    idle(12, "R9");
    step(4, 2, 0, "R9");
    idle(6, "R9");

    // R5: every speed select
    for (int s = 0; s < 4; s++) begin
      speedBin = 2'(s);
      idle(1, "R5");
      step(1, 1, 0, "R5");
      for (int i = 0; i < 22; i++) step(4, 1, 0, "R5");
      for (int i = 0; i < 8; i++) step(1, 1, 0, "R5");
      for (int i = 0; i < 22; i++) step(2, 1, (i == 21), "R5");
      idle(30, "R5");
    end

    // R7: random mix
    for (int i = 0; i < 3000; i++) begin
      int b, c, r;
      if (i % 500 == 499) speedBin = 2'($urandom % 4);
      b = $urandom % 4;
      r = $urandom % 10;
      c = $urandom % 8;
      if (r < 6) begin
        c = 0;
        for (int k = 1; k <= 4; k++)
          if (legalAt(b, k, edgeN) && ($urandom % 2 == 0)) c = k;
      end
      step(c, b, ($urandom % 3 == 0), "R7");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule